// File: doc/BRIEF.md
# Slot I/O Window Register File and Decoder

This block serves one card slot of a host-bus to card-bus bridge. Software reaches a small bank of 8-bit registers through two ports. A write to the index port selects a register. A read or write on the data port then acts on the selected register. The bank holds a fixed identity value, a control register that carries the card-type flag, an enable register, and the start and stop limits of two I/O windows. Each limit is split into a low byte and a high byte.

On every host I/O cycle the block compares the 16-bit address with both windows and reports which window claimed it, one cycle later, as a registered one-hot code. The address passes to the card unchanged, so the block only decides ownership and does no translation. Window 0 wins when both windows match.

Top module: `slot_iowin_decoder`

## Requirements
- R1: A write with `reg_sel`=0 latches `reg_wdata` as the current index, and a read with `reg_sel`=0 returns that index on `reg_rdata` on the following cycle.
- R2: A read with `reg_sel`=1 returns the register selected by the current index on `reg_rdata` on the cycle after the request. `reg_rdata` holds its value when no read is requested.
- R3: Index 00h always reads 83h, and data-port writes to it have no effect.
- R4: Index 03h is a read/write byte. Its bit 5 gives the card type (1 = I/O card, 0 = memory card) and is driven on `card_is_io`.
- R5: Window 0 start low/high bytes are at 08h/09h and stop low/high bytes at 0Ah/0Bh. Window 1 uses 0Ch/0Dh/0Eh/0Fh in the same arrangement. All eight bytes read back what was written.
- R6: An enabled window matches an address when start ≤ address ≤ stop, compared as unsigned 16-bit values. Both limits are inclusive and the granularity is one byte.
- R7: A window whose start is greater than its stop never matches.
- R8: Index 06h bit 6 enables window 0 and bit 7 enables window 1. A disabled window never matches. The other bits of 06h read as 0.
- R9: `win_hit` is one-hot or zero: bit 0 means window 0 and bit 1 means window 1. When both windows match, only bit 0 is set.
- R10: `win_hit` reflects the address presented with `io_cycle`=1 on the previous clock, and is 00 after a cycle in which `io_cycle` was 0.
- R11: After reset every writable register is 00h, and every index other than 00h, 03h, 06h and 08h–0Fh reads 00h, even after being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 = index port, 1 = data port |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| io_cycle | input | 1 | Host I/O cycle qualifier |
| io_addr | input | 16 | Host I/O address |
| win_hit | output | 2 | Registered one-hot window match |
| card_is_io | output | 1 | Card-type flag from control bit 5 |

## Verification
A corrupted limit byte or enable bit shows up at `win_hit` on the very next I/O cycle whose address lies between the true and the corrupted limit. For this reason the bench sweeps all 65,536 addresses against two overlapping windows and checks that edges and the overlap are exact to the byte. A wrong index decode shows on `reg_rdata` one cycle after the read, so every one of the 256 indices is written and read back. Degenerate windows and disabled windows are probed at their own limits, where an off-by-one error in a comparison or a swapped enable bit appears at once.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int REG_W       = 8;
  localparam int IDX_ID      = 8'h00;
  localparam int IDX_CTRL    = 8'h03;
  localparam int IDX_EN      = 8'h06;
  localparam int IDX_WINBASE = 8'h08;
  localparam int EN_LSB      = 6;
  localparam int TYPE_BIT    = 5;
  localparam logic [REG_W-1:0] ID_VALUE = 8'h83;
endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_sel,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [REG_W-1:0]               reg_wdata,
  output logic [REG_W-1:0]               reg_rdata,
  output logic                           card_is_io,
  output logic [NUM_WIN-1:0]             win_en,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] win_start,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] win_stop
);
  localparam int AB     = ADDR_W / REG_W;
  localparam int STRIDE = 2 * AB;

  logic [REG_W-1:0] index_q;
  logic [REG_W-1:0] ctrl_q;
  logic [NUM_WIN-1:0] en_q;
  logic [REG_W-1:0] lim_q [NUM_WIN][STRIDE];
  logic [REG_W-1:0] rd_val;
  logic data_wr;

  assign data_wr = reg_wr && reg_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ctrl_q  <= '0;
      en_q    <= '0;
    end else begin
      if (reg_wr && !reg_sel) index_q <= reg_wdata;
      if (data_wr && index_q == REG_W'(IDX_CTRL)) ctrl_q <= reg_wdata;
      if (data_wr && index_q == REG_W'(IDX_EN)) en_q <= reg_wdata[EN_LSB +: NUM_WIN];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar j = 0; j < STRIDE; j++) begin : g_byte
      localparam logic [REG_W-1:0] MY_IDX = REG_W'(IDX_WINBASE + w * STRIDE + j);
      always_ff @(posedge clk) begin
        if (rst) lim_q[w][j] <= '0;
        else if (data_wr && index_q == MY_IDX) lim_q[w][j] <= reg_wdata;
      end
    end
    always_comb begin
      for (int j = 0; j < AB; j++) begin
        win_start[w][REG_W*j +: REG_W] = lim_q[w][j];
        win_stop[w][REG_W*j +: REG_W]  = lim_q[w][AB + j];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (index_q == REG_W'(IDX_ID))   rd_val = ID_VALUE;
    if (index_q == REG_W'(IDX_CTRL)) rd_val = ctrl_q;
    if (index_q == REG_W'(IDX_EN))   rd_val[EN_LSB +: NUM_WIN] = en_q;
    for (int w = 0; w < NUM_WIN; w++)
      for (int j = 0; j < STRIDE; j++)
        if (index_q == REG_W'(IDX_WINBASE + w * STRIDE + j)) rd_val = lim_q[w][j];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= reg_sel ? rd_val : index_q;
  end

  assign card_is_io = ctrl_q[TYPE_BIT];
  assign win_en     = en_q;

  // R3: identity register read always yields the fixed value
  a_r3_id_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel && index_q == REG_W'(IDX_ID)) |=> reg_rdata == ID_VALUE);

  // R1: index port read reflects the latched index
  a_r1_index_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_sel && !reg_wr) |=> reg_rdata == $past(index_q));
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int ADDR_W = 16
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              hit
);
  logic above_lo, below_hi;
  assign above_lo = addr >= lo;
  assign below_hi = addr <= hi;
  assign hit      = en && above_lo && below_hi;
endmodule

// File: rtl/iowin_prio.sv
module iowin_prio #(
  parameter int NUM_WIN = 2
) (
  input  logic [NUM_WIN-1:0] raw,
  output logic [NUM_WIN-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--)
      if (raw[w]) sel = NUM_WIN'(1) << w;
  end
endmodule

// File: rtl/slot_iowin_decoder.sv
module slot_iowin_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               io_cycle,
  input  logic [ADDR_W-1:0]  io_addr,
  output logic [NUM_WIN-1:0] win_hit,
  output logic               card_is_io
);
  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_start;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_stop;
  logic [NUM_WIN-1:0]             raw_hit;
  logic [NUM_WIN-1:0]             pick;

  iowin_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) i_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_is_io(card_is_io),
    .win_en(win_en), .win_start(win_start), .win_stop(win_stop)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    iowin_match #(.ADDR_W(ADDR_W)) i_match (
      .en(win_en[w]), .addr(io_addr), .lo(win_start[w]), .hi(win_stop[w]),
      .hit(raw_hit[w])
    );

    // R7: a hit is only possible when the window was well formed
    a_r7_ordered: assert property (@(posedge clk) disable iff (rst)
      win_hit[w] |-> $past(win_start[w] <= win_stop[w]));

    // R8: a hit requires the window to have been enabled
    a_r8_enabled: assert property (@(posedge clk) disable iff (rst)
      win_hit[w] |-> $past(win_en[w]));
  end

  iowin_prio #(.NUM_WIN(NUM_WIN)) i_prio (.raw(raw_hit), .sel(pick));

  always_ff @(posedge clk) begin
    if (rst) win_hit <= '0;
    else     win_hit <= io_cycle ? pick : '0;
  end

  // R9: the output is never more than one window
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_hit));

  // R9: window 1 is reported only when window 0 did not match
  a_r9_priority: assert property (@(posedge clk) disable iff (rst)
    win_hit[1] |-> !$past(raw_hit[0]));

  // R10: a hit follows an active host cycle
  a_r10_needs_cycle: assert property (@(posedge clk) disable iff (rst)
    (win_hit != '0) |-> $past(io_cycle));
endmodule

// File: tb/test_slot_iowin_decoder.sv
module test_slot_iowin_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_sel, reg_wr, reg_rd;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        io_cycle;
  logic [15:0] io_addr;
  logic [1:0]  win_hit;
  logic        card_is_io;

  int checks = 0;
  int errors = 0;

  logic [15:0] s0, e0, s1, e1;
  logic        en0, en1;

  always #10 clk = ~clk;

  slot_iowin_decoder i_slot_iowin_decoder (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_cycle(io_cycle),
    .io_addr(io_addr), .win_hit(win_hit), .card_is_io(card_is_io)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic sel, input logic wr, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = wr; reg_rd = !wr; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
    acc(1'b0, 1'b1, idx);
    acc(1'b1, 1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [7:0] d);
    acc(1'b0, 1'b1, idx);
    acc(1'b1, 1'b0, 8'h00);
    d = reg_rdata;
  endtask

  task automatic set_win(input int w, input logic [15:0] s, input logic [15:0] e);
    logic [7:0] b;
    b = 8'h08 + 8'(4 * w);
    wreg(b,        s[7:0]);
    wreg(b + 8'd1, s[15:8]);
    wreg(b + 8'd2, e[7:0]);
    wreg(b + 8'd3, e[15:8]);
    if (w == 0) begin s0 = s; e0 = e; end
    else        begin s1 = s; e1 = e; end
  endtask

  task automatic set_en(input logic a, input logic b);
    en0 = a; en1 = b;
    wreg(8'h06, {b, a, 6'h3F});
  endtask

  function automatic logic [1:0] exp_hit(input logic v, input logic [15:0] a);
    logic h0, h1;
    h0 = en0 && s0 <= a && a <= e0;
    h1 = en1 && s1 <= a && a <= e1;
    if (!v)      return 2'b00;
    else if (h0) return 2'b01;
    else if (h1) return 2'b10;
    else         return 2'b00;
  endfunction

  // caller stands at a negedge; one cycle per probe
  task automatic probe(input string req, input logic v, input logic [15:0] a);
    io_cycle = v; io_addr = a;
    @(negedge clk);
    check(req, {14'h0, win_hit}, {14'h0, exp_hit(v, a)});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    rst = 1'b1; reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    io_cycle = 0; io_addr = 0;
    s0 = 0; e0 = 0; s1 = 0; e1 = 0; en0 = 0; en1 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 hit after reset", {14'h0, win_hit}, 16'h0);
    check("R4 card type after reset", {15'h0, card_is_io}, 16'h0);
    for (int i = 3; i < 16; i++) begin
      if (i == 4 || i == 5 || i == 7) continue;
      rreg(8'(i), d);
      check("R11 reset value", {8'h0, d}, 16'h0);
    end

    // R1 index port read-back
    acc(1'b0, 1'b1, 8'h5A);
    acc(1'b0, 1'b0, 8'h00);
    check("R1 index read", {8'h0, reg_rdata}, 16'h005A);

    // R3 identity, write ignored
    rreg(8'h00, d);
    check("R3 id", {8'h0, d}, 16'h0083);
    wreg(8'h00, 8'h55);
    rreg(8'h00, d);
    check("R3 id after write", {8'h0, d}, 16'h0083);

    // R2 read data holds without a read strobe
    repeat (2) @(negedge clk);
    check("R2 rdata hold", {8'h0, reg_rdata}, 16'h0083);

    // R4 control and card type
    wreg(8'h03, 8'hA5);
    rreg(8'h03, d);
    check("R4 ctrl readback", {8'h0, d}, 16'h00A5);
    check("R4 io card", {15'h0, card_is_io}, 16'h1);
    wreg(8'h03, 8'hDF);
    check("R4 memory card", {15'h0, card_is_io}, 16'h0);

    // R8 enable register layout
    wreg(8'h06, 8'hFF);
    rreg(8'h06, d);
    check("R8 enable readback", {8'h0, d}, 16'h00C0);

    // R11 unimplemented indices
    for (int i = 0; i < 256; i++) begin
      if (i == 0 || i == 3 || i == 6 || (i >= 8 && i <= 15)) continue;
      wreg(8'(i), 8'hFF);
      rreg(8'(i), d);
      check("R11 unimplemented", {8'h0, d}, 16'h0);
    end

    // R5 byte layout
    set_win(0, 16'h1000, 16'h10FF);
    set_win(1, 16'h10F0, 16'h2000);
    for (int i = 8; i < 16; i++) begin
      logic [15:0] v;
      case (i)
        8:  v = 16'h00; 9:  v = 16'h10; 10: v = 16'hFF; 11: v = 16'h10;
        12: v = 16'hF0; 13: v = 16'h10; 14: v = 16'h00; default: v = 16'h20;
      endcase
      rreg(8'(i), d);
      check("R5 window byte", {8'h0, d}, v);
    end

    // R6 R9 full address sweep with overlapping windows
    set_en(1'b1, 1'b1);
    for (int a = 0; a < 65536; a++)
      probe("R6 R9 sweep", 1'b1, 16'(a));

    // R10 no cycle, no hit
    probe("R10 idle", 1'b0, 16'h1000);
    probe("R10 idle in win1", 1'b0, 16'h1500);
    probe("R10 after idle", 1'b1, 16'h1500);

    // R7 inverted window, top-edge window
    set_win(0, 16'h3000, 16'h2FFF);
    set_win(1, 16'hFFFF, 16'hFFFF);
    probe("R7 below", 1'b1, 16'h2FFF);
    probe("R7 above", 1'b1, 16'h3000);
    probe("R6 top edge", 1'b1, 16'hFFFF);
    probe("R6 top minus one", 1'b1, 16'hFFFE);
    probe("R6 zero", 1'b1, 16'h0000);

    // R8 disabled window 0 covering everything
    set_win(0, 16'h0000, 16'hFFFF);
    set_win(1, 16'h8000, 16'h80FF);
    set_en(1'b0, 1'b1);
    probe("R8 win0 off", 1'b1, 16'h8000);
    probe("R8 win0 off miss", 1'b1, 16'h0000);
    probe("R8 win0 off edge", 1'b1, 16'h80FF);
    probe("R8 win0 off past", 1'b1, 16'h8100);
    set_en(1'b1, 1'b0);
    probe("R8 win1 off", 1'b1, 16'h8000);
    set_en(1'b0, 1'b0);
    probe("R8 both off", 1'b1, 16'h8000);
    io_cycle = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule